// File: doc/BRIEF.md
# Prescaled High-Speed Binary Counter

A free-running binary up-counter meant for high clock rates. The count is kept in two register groups on one clock: a narrow low-order prescaler that steps on every enabled clock, and a wide high-order counter that steps only once per full prescaler cycle. The high-order counter is gated by a single-cycle carry pulse that comes straight from a flip-flop. The long carry chain of the wide part therefore has several clocks to settle, and only the narrow part has to meet a single-cycle path.

The output is the two parts joined, high over low. It reads as an ordinary binary count that goes up by one on each enabled clock and wraps to zero after all values have been visited. A global enable freezes the whole counter. A synchronous active-high reset clears it. A terminal flag, selected by a parameter, marks the cycle in which the count is all ones.

Top module: `presc_counter`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, clears the count output, the terminal flag and the pending carry pulse to zero.
- R2: On each rising edge with `cnt_en` high and no reset, `count_o` increases by exactly one.
- R3: On an edge with `cnt_en` low, the count, the terminal flag and the pending carry are all held.
- R4: The high part (`count_o[CNT_W-1:PRE_W]`, 30 bits by default) changes only on an enabled edge at which the low part (`count_o[PRE_W-1:0]`, 2 bits by default) wraps from all ones to zero.
- R5: The carry pulse is a register output. It is high exactly while the low part holds its all-ones value.
- R6: After 2^CNT_W enabled clocks the count wraps from all ones back to zero.
- R7: With `TC_EN` = 1 (the default), `term_o` is 1 exactly while `count_o` is all ones, including while the count is frozen there. With `TC_EN` = 0 it stays 0.
- R8: Reset takes priority over `cnt_en`: an edge with both inputs high leaves the count at zero.
- R9: Between two changes of the high part there are at least 2^PRE_W clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both count parts |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Global count enable; when low, all state holds |
| count_o | output | CNT_W | Count value, high part over low part |
| term_o | output | 1 | High while the count is all ones |

## Verification
The critical coincidence is a pending carry pulse together with a drop of the count enable, or with a reset. It happens when the low part sits at all ones with the carry armed. The stimulus steers the count to that point and then removes the enable for several cycles before stepping again, and it also asserts reset with the enable high in the middle of a count. A behavioural reference count is compared with the port value on every clock. This exposes a lost or doubled high-part step, and a pulse that survives reset. A narrow instance is run through its full range so that the terminal flag and the wrap meet on the same edge, with a freeze at all ones in between.

// File: rtl/pctr_pkg.sv
package pctr_pkg;

  // State of the registered carry pulse that gates the wide counter
  typedef enum logic {
    CARRY_IDLE  = 1'b0,
    CARRY_ARMED = 1'b1
  } carry_state_e;

endpackage

// File: rtl/pctr_prescale.sv
module pctr_prescale
  import pctr_pkg::*;
#(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [PRE_W-1:0] pre_o,
  output logic             carry_o
);

  // the value one below the wrap point arms the carry for the next cycle
  localparam logic [PRE_W-1:0] PRE_ARM = PRE_W'((2 ** PRE_W) - 2);

  logic [PRE_W-1:0] pre_q;
  carry_state_e     carry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      carry_q <= CARRY_IDLE;
    end else if (en) begin
      pre_q   <= pre_q + 1'b1;
      carry_q <= (pre_q == PRE_ARM) ? CARRY_ARMED : CARRY_IDLE;
    end
  end

  assign pre_o   = pre_q;
  assign carry_o = (carry_q == CARRY_ARMED);

endmodule

// File: rtl/pctr_upper.sv
module pctr_upper #(
  parameter int HI_W = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic [HI_W-1:0] hi_o
);

  logic [HI_W-1:0] hi_q;

  // wide carry chain: its inputs only change once per prescaler cycle
  always_ff @(posedge clk) begin
    if (rst)       hi_q <= '0;
    else if (step) hi_q <= hi_q + 1'b1;
  end

  assign hi_o = hi_q;

endmodule

// File: rtl/pctr_term_flag.sv
module pctr_term_flag #(
  parameter int PRE_W = 2,
  parameter int HI_W  = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PRE_W-1:0] pre,
  input  logic [HI_W-1:0]  hi,
  output logic             term_o
);

  localparam logic [PRE_W-1:0] PRE_ARM = PRE_W'((2 ** PRE_W) - 2);

  logic hi_full;
  logic term_q;

  // the wide compare sees stable inputs for a whole prescaler cycle
  assign hi_full = &hi;

  always_ff @(posedge clk) begin
    if (rst)     term_q <= 1'b0;
    else if (en) term_q <= hi_full && (pre == PRE_ARM);
  end

  assign term_o = term_q;

endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 2,
  parameter bit TC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count_o,
  output logic             term_o
);

  localparam int HI_W = CNT_W - PRE_W;

  logic [PRE_W-1:0] pre_q;
  logic [HI_W-1:0]  hi_q;
  logic             carry_q;
  logic             hi_step;

  pctr_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .en      (cnt_en),
    .pre_o   (pre_q),
    .carry_o (carry_q)
  );

  assign hi_step = cnt_en & carry_q;

  pctr_upper #(.HI_W(HI_W)) u_upper (
    .clk  (clk),
    .rst  (rst),
    .step (hi_step),
    .hi_o (hi_q)
  );

  generate
    if (TC_EN) begin : g_term
      pctr_term_flag #(.PRE_W(PRE_W), .HI_W(HI_W)) u_term (
        .clk    (clk),
        .rst    (rst),
        .en     (cnt_en),
        .pre    (pre_q),
        .hi     (hi_q),
        .term_o (term_o)
      );
    end else begin : g_no_term
      assign term_o = 1'b0;
    end
  endgenerate

  assign count_o = {hi_q, pre_q};

endmodule

// File: rtl/presc_counter_chk.sv
module presc_counter_chk #(
  parameter int PRE_W = 2,
  parameter int HI_W  = 30,
  parameter bit TC_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [PRE_W-1:0] pre,
  input logic [HI_W-1:0]  hi,
  input logic             carry,
  input logic             tc
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam int GAP_MIN = (2 ** PRE_W) - 1;

  // cycles since the high part last changed, saturating
  logic [HI_W-1:0] hi_prev;
  logic [PRE_W:0]  gap_q;
  logic            hi_moved;

  assign hi_moved = (hi != hi_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_prev <= '0;
      gap_q   <= '0;
    end else begin
      hi_prev <= hi;
      if (hi_moved)                       gap_q <= '0;
      else if (gap_q != (PRE_W+1)'(GAP_MIN)) gap_q <= gap_q + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pre == '0 && hi == '0 && !carry && !tc));

  assert_low_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (pre == PRE_W'($past(pre) + 1'b1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pre) && $stable(hi) && $stable(carry) && $stable(tc)));

  assert_hi_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (en && pre == PRE_LAST) |=> (hi == HI_W'($past(hi) + 1'b1)));

  assert_hi_still_R4: assert property (@(posedge clk) disable iff (rst)
    !(en && pre == PRE_LAST) |=> $stable(hi));

  assert_carry_phase_R5: assert property (@(posedge clk) disable iff (rst)
    carry == (pre == PRE_LAST));

  assert_term_flag_R7: assert property (@(posedge clk) disable iff (rst)
    tc == (TC_EN && (&{hi, pre})));

  assert_hi_gap_R9: assert property (@(posedge clk) disable iff (rst)
    hi_moved |-> (gap_q >= (PRE_W+1)'(GAP_MIN)));

endmodule

bind presc_counter presc_counter_chk #(
  .PRE_W (PRE_W),
  .HI_W  (HI_W),
  .TC_EN (TC_EN)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (cnt_en),
  .pre   (pre_q),
  .hi    (hi_q),
  .carry (carry_q),
  .tc    (term_o)
);

// File: tb/presc_counter_bench.sv
module presc_counter_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;

  always #5 clk = ~clk;

  logic [31:0] cnt_big;
  logic        tc_big;
  logic [9:0]  cnt_sm;
  logic        tc_sm;

  presc_counter u_presc_counter (
    .clk (clk), .rst (rst), .cnt_en (en), .count_o (cnt_big), .term_o (tc_big)
  );

  presc_counter #(.CNT_W(10)) u_presc_counter_small (
    .clk (clk), .rst (rst), .cnt_en (en), .count_o (cnt_sm), .term_o (tc_sm)
  );

  longint m_big = 0;
  longint m_sm  = 0;
  int     checks = 0;
  int     fails  = 0;
  bit     done   = 1'b0;
  string  tag    = "R1";

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at the falling edge, model the rising edge, compare at the next fall
  task automatic step(input logic r, input logic e);
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) begin
      m_big = 0;
      m_sm  = 0;
    end else if (e) begin
      m_big = (m_big + 1) % (64'd1 << 32);
      m_sm  = (m_sm + 1) % 1024;
    end
    @(negedge clk);
    check("count32", longint'(cnt_big), m_big);
    check("term32",  longint'(tc_big),  longint'(m_big == 64'hFFFF_FFFF));
    check("count10", longint'(cnt_sm),  m_sm);
    check("term10",  longint'(tc_sm),   longint'(m_sm == 1023));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);

    tag = "R2 R4 R9";
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1);

    tag = "R3";
    for (int i = 0; i < 60; i++) step(1'b0, (i % 3) != 0);

    // freeze with the carry armed (low part all ones)
    while (m_big % 4 != 3) step(1'b0, 1'b1);
    tag = "R5 R3";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    tag = "R5 R4";
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

    // reset with enable high, once with the carry armed
    while (m_big % 4 != 3) step(1'b0, 1'b1);
    tag = "R8";
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    tag = "R8 R1";
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

    // narrow instance: reach all ones, freeze there, then wrap
    tag = "R2 R6";
    while (m_sm != 1023) step(1'b0, 1'b1);
    tag = "R7";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    tag = "R6 R7";
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);

    tag = "R6";
    for (int i = 0; i < 1030; i++) step(1'b0, (i % 7) != 3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule